// File: doc/BRIEF.md
# Host I/O Bus Command Sequencer

This block runs one single-word I/O instruction on a shared parallel device bus. It is the host side of the exchange. A request names a command type, a 10-bit word that holds both the function code and the device select, and a 16-bit data word. The sequencer latches the request and opens a fixed frame of `FRAME_CYC` clock cycles. For the whole frame it holds the address word on the address bus. Within the frame it fires the command strobes that the type calls for, at cycle offsets set by parameters.

The device answers on an active-low reply line. The sequencer samples that line at one fixed cycle. A positive reply means two things: the data was accepted, and the next instruction is to be skipped. On the cycle after the frame ends, the block reports a done pulse, the skip flag and any captured input word. Every bus output is active low and rests high between frames. With the default 10 ns clock, the defaults give a 3 us frame, a reply sample 1.2 us in, a capture at 2.3 us and strobes 200 ns wide.

The controller has four states, driven by a frame counter:

| State | Role | Transition |
|---|---|---|
| IDLE | Bus at rest; waits for a request. | IDLE→ADDR on `req_valid`. |
| ADDR | Address driven; counts up to the reply sample point. | ADDR→POST at count `REPLY_AT`, where the reply is sampled. |
| POST | Mid-frame and late strobes. | POST→DONE at count `FRAME_CYC-1`. |
| DONE | One cycle with `done` high and the bus released. | DONE→IDLE unconditionally. |

Top module: `iobus_seq`

## Requirements
- R1: After reset and whenever `busy` is low, every active-low bus output is high and `done` is low. After reset, `skip` and `rd_data` are 0.
- R2: From the cycle after acceptance, `adb_n` equals the inverted request address for exactly `FRAME_CYC` cycles. It returns to all ones in the DONE cycle.
- R3: With command code 0 (mode-set), `cmd_stb_n` is low for `PULSE_W` cycles starting at frame cycle `FRAME_CYC/2`. No other strobe fires, and `skip` ends at 0.
- R4: With code 1 (condition test), `reply_n` is sampled only in frame cycle `REPLY_AT`. `skip` ends equal to the inverse of that sample.
- R5: With code 2 (input), if a reply was sampled, `rd_data` takes the inverse of `inb_n` as seen in frame cycle `CAPTURE_AT`. `rdy_clr_n` is low for `PULSE_W` cycles from `CAPTURE_AT`, and `skip` ends at 1.
- R6: With code 2 and no reply, `rd_data` keeps its previous value, `rdy_clr_n` stays high and `skip` ends at 0.
- R7: With code 3 (output), `otb_n` carries the inverted data word for the whole frame. `wr_stb_n` is low for `PULSE_W` cycles from `CAPTURE_AT` only if a reply was sampled, and `skip` equals the reply.
- R8: With code 4 (set-mask), `otb_n` carries the inverted mask word for the whole frame. `mask_stb_n` is low for `PULSE_W` cycles from `FRAME_CYC/2`, and `skip` ends at 0 whatever the reply.
- R9: `done` is a one-cycle pulse in the cycle after the last frame cycle. `busy` is high from the cycle after acceptance through the done cycle.
- R10: A request raised while `busy` is high, including in the done cycle, is ignored. It does not alter the running frame's bus outputs or results.
- R11: Codes 5 to 7 run a full frame with the address driven, fire no strobe and leave `skip` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_cmd | input | 3 | Command type code |
| req_addr | input | 10 | Function code and device select word |
| req_wdata | input | 16 | Output data or mask word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| skip | output | 1 | Reply seen for a command that samples it |
| rd_data | output | 16 | Last accepted input word |
| adb_n | output | 10 | Address bus, active low |
| otb_n | output | 16 | Output data bus, active low |
| inb_n | input | 16 | Input data bus, active low |
| reply_n | input | 1 | Device reply line, active low |
| cmd_stb_n | output | 1 | Mode-set strobe, active low |
| rdy_clr_n | output | 1 | Reset-ready pulse on input accept, active low |
| wr_stb_n | output | 1 | Output data strobe, active low |
| mask_stb_n | output | 1 | Set-mask strobe, active low |

## Verification
Two events can land on the same cycle: the done pulse that closes a frame, and a new request that meets a still-busy sequencer. The bench provokes this by raising a request with random fields in the done cycle of many frames. It then expects `busy` to be low on the next cycle, so the request was dropped, and the next frame starts only from its own request. The reply and input buses are also driven with random noise on every cycle except the sample and capture cycles. A sample taken at the wrong offset therefore shows up in `skip`, `rd_data` or the late strobes.

// File: rtl/iobus_seq_pkg.sv
package iobus_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_POST,
        ST_DONE
    } seq_state_t;

    localparam logic [2:0] CMD_MODE = 3'd0;
    localparam logic [2:0] CMD_TEST = 3'd1;
    localparam logic [2:0] CMD_IN   = 3'd2;
    localparam logic [2:0] CMD_OUT  = 3'd3;
    localparam logic [2:0] CMD_MASK = 3'd4;

endpackage

// File: rtl/iobus_seq_win.sv
module iobus_seq_win #(
    parameter int CNT_W = 9,
    parameter int START = 150,
    parameter int LEN   = 20
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             en,
    output logic             on
);
    localparam logic [CNT_W:0] LO = (CNT_W+1)'(START);
    localparam logic [CNT_W:0] HI = (CNT_W+1)'(START + LEN);

    always_comb begin
        on = en && ({1'b0, cnt} >= LO) && ({1'b0, cnt} < HI);
    end
endmodule

// File: rtl/iobus_seq.sv
module iobus_seq
    import iobus_seq_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int FRAME_CYC  = 300,
    parameter int REPLY_AT   = 120,
    parameter int CAPTURE_AT = 230,
    parameter int PULSE_W    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              skip,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] adb_n,
    output logic [DATA_W-1:0] otb_n,
    input  logic [DATA_W-1:0] inb_n,
    input  logic              reply_n,
    output logic              cmd_stb_n,
    output logic              rdy_clr_n,
    output logic              wr_stb_n,
    output logic              mask_stb_n
);
    localparam int CNT_W  = $clog2(FRAME_CYC + 1);
    localparam int MID_AT = FRAME_CYC / 2;
    localparam logic [CNT_W-1:0] REPLY_C = CNT_W'(REPLY_AT);
    localparam logic [CNT_W-1:0] CAPT_C  = CNT_W'(CAPTURE_AT);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(FRAME_CYC - 1);

    seq_state_t        st, st_nx;
    logic [CNT_W-1:0]  cnt;
    logic [2:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              hit_q;
    logic              skip_q;
    logic [DATA_W-1:0] rdata_q;
    logic              in_frame;
    logic              mid_on, late_on;
    logic              samples_reply;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (req_valid)      st_nx = ST_ADDR;
            ST_ADDR: if (cnt == REPLY_C) st_nx = ST_POST;
            ST_POST: if (cnt == LAST_C)  st_nx = ST_DONE;
            ST_DONE:                     st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    assign samples_reply = (cmd_q == CMD_TEST) || (cmd_q == CMD_IN) || (cmd_q == CMD_OUT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            cmd_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            hit_q   <= 1'b0;
            skip_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (st == ST_IDLE && req_valid) begin
                cnt     <= '0;
                cmd_q   <= req_cmd;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                hit_q   <= 1'b0;
                skip_q  <= 1'b0;
            end else if (st == ST_ADDR || st == ST_POST) begin
                cnt <= cnt + 1'b1;
            end
            if (st == ST_ADDR && cnt == REPLY_C && samples_reply) begin
                hit_q  <= ~reply_n;
                skip_q <= ~reply_n;
            end
            if (st == ST_POST && cnt == CAPT_C && hit_q && cmd_q == CMD_IN) begin
                rdata_q <= ~inb_n;
            end
        end
    end

    assign in_frame = (st == ST_ADDR) || (st == ST_POST);

    iobus_seq_win #(.CNT_W(CNT_W), .START(MID_AT), .LEN(PULSE_W)) u_win_mid (
        .cnt(cnt), .en(in_frame), .on(mid_on)
    );
    iobus_seq_win #(.CNT_W(CNT_W), .START(CAPTURE_AT), .LEN(PULSE_W)) u_win_late (
        .cnt(cnt), .en(in_frame), .on(late_on)
    );

    always_comb begin
        busy       = (st != ST_IDLE);
        done       = (st == ST_DONE);
        skip       = skip_q;
        rd_data    = rdata_q;
        adb_n      = in_frame ? ~addr_q : '1;
        otb_n      = (in_frame && (cmd_q == CMD_OUT || cmd_q == CMD_MASK)) ? ~wdata_q : '1;
        cmd_stb_n  = ~(mid_on && cmd_q == CMD_MODE);
        mask_stb_n = ~(mid_on && cmd_q == CMD_MASK);
        rdy_clr_n  = ~(late_on && hit_q && cmd_q == CMD_IN);
        wr_stb_n   = ~(late_on && hit_q && cmd_q == CMD_OUT);
    end
endmodule

// File: rtl/iobus_seq_chk.sv
module iobus_seq_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              skip,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] adb_n,
    input logic [DATA_W-1:0] otb_n,
    input logic              cmd_stb_n,
    input logic              rdy_clr_n,
    input logic              wr_stb_n,
    input logic              mask_stb_n
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (adb_n == '1 && otb_n == '1 && cmd_stb_n && rdy_clr_n && wr_stb_n && mask_stb_n && !done));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (done || $stable(adb_n)));

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~cmd_stb_n, ~rdy_clr_n, ~wr_stb_n, ~mask_stb_n}) <= 1);

    p_skip_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(skip));

    p_rdata_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rd_data));

    p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind iobus_seq iobus_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/iobus_seq_tb.sv
module iobus_seq_tb;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int FR = 300;
    localparam int RA = 120;
    localparam int CA = 230;
    localparam int PW = 20;
    localparam int MID = FR / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic busy, done, skip;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] adb_n;
    logic [DW-1:0] otb_n;
    logic [DW-1:0] inb_n = '1;
    logic reply_n = 1'b1;
    logic cmd_stb_n, rdy_clr_n, wr_stb_n, mask_stb_n;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_rdata = '0;

    always #5 clk = ~clk;

    iobus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .skip(skip), .rd_data(rd_data), .adb_n(adb_n), .otb_n(otb_n),
        .inb_n(inb_n), .reply_n(reply_n), .cmd_stb_n(cmd_stb_n),
        .rdy_clr_n(rdy_clr_n), .wr_stb_n(wr_stb_n), .mask_stb_n(mask_stb_n)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] cmd, input logic rep);
        case (cmd)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return rep ? "R5" : "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [3:0] exp_strobes(input logic [2:0] cmd, input logic rep, input int c);
        logic mid, late;
        mid  = (c >= MID) && (c < MID + PW);
        late = (c >= CA) && (c < CA + PW);
        return {~(mid && cmd == 3'd0), ~(mid && cmd == 3'd4),
                ~(late && cmd == 3'd2 && rep), ~(late && cmd == 3'd3 && rep)};
    endfunction

    function automatic logic exp_skip(input logic [2:0] cmd, input logic rep);
        return (cmd == 3'd1 || cmd == 3'd2 || cmd == 3'd3) && rep;
    endfunction

    task automatic run_frame(input logic [2:0] cmd, input logic [AW-1:0] addr,
                             input logic [DW-1:0] wd, input logic rep,
                             input logic [DW-1:0] indata, input logic noisy);
        int bad_a, bad_o, bad_s, bad_b;
        logic [31:0] act_s, exp_s, act_a, act_o;
        logic [DW-1:0] e_otb;
        string t;
        t = tag_of(cmd, rep);
        bad_a = 0; bad_o = 0; bad_s = 0; bad_b = 0;
        act_s = '0; exp_s = '0; act_a = '0; act_o = '0;
        e_otb = (cmd == 3'd3 || cmd == 3'd4) ? ~wd : '1;
        req_cmd = cmd; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        for (int c = 0; c < FR; c++) begin
            req_valid = noisy ? 1'($urandom % 2) : 1'b0;
            if (noisy) begin
                req_cmd = 3'($urandom); req_addr = AW'($urandom); req_wdata = DW'($urandom);
            end
            reply_n = (c == RA) ? ~rep : 1'($urandom);
            inb_n   = (c == CA) ? ~indata : DW'($urandom);
            if (adb_n !== ~addr) begin bad_a++; act_a = 32'(adb_n); end
            if (otb_n !== e_otb) begin bad_o++; act_o = 32'(otb_n); end
            if ({cmd_stb_n, mask_stb_n, rdy_clr_n, wr_stb_n} !== exp_strobes(cmd, rep, c)) begin
                bad_s++;
                act_s = {c[27:0], cmd_stb_n, mask_stb_n, rdy_clr_n, wr_stb_n};
                exp_s = {c[27:0], exp_strobes(cmd, rep, c)};
            end
            if (busy !== 1'b1 || done !== 1'b0) bad_b++;
            @(posedge clk); @(negedge clk);
        end
        req_valid = 1'b0;
        reply_n = 1'b1; inb_n = '1;
        chk(bad_a == 0, "R2 address held for frame", act_a, 32'(~addr));
        chk(bad_o == 0, (cmd == 3'd4) ? "R8 output bus" : "R7 output bus", act_o, 32'(e_otb));
        chk(bad_s == 0, {t, " strobe timing"}, act_s, exp_s);
        chk(bad_b == 0, noisy ? "R10 busy frame ignores requests" : "R9 busy through frame", 32'(bad_b), 0);
        if (cmd == 3'd2 && rep) exp_rdata = indata;
        chk(done === 1'b1 && busy === 1'b1, "R9 done pulse", {30'd0, busy, done}, 32'd3);
        chk(adb_n === '1, "R2 address released", 32'(adb_n), 32'h3ff);
        chk(skip === exp_skip(cmd, rep), {t, " skip"}, 32'(skip), 32'(exp_skip(cmd, rep)));
        chk(rd_data === exp_rdata, (cmd == 3'd2) ? {t, " input word"} : "R6 input word kept", 32'(rd_data), 32'(exp_rdata));
        if (noisy) begin
            req_valid = 1'b1; req_cmd = 3'($urandom); req_addr = AW'($urandom); req_wdata = DW'($urandom);
        end
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b0 && done === 1'b0, "R10 request in done cycle ignored", {30'd0, busy, done}, 0);
        chk(adb_n === '1 && otb_n === '1, "R1 bus at rest", 32'(adb_n), 32'h3ff);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        chk(adb_n === '1 && otb_n === '1 && {cmd_stb_n, rdy_clr_n, wr_stb_n, mask_stb_n} === 4'hf,
            "R1 reset bus idle", 32'(adb_n), 32'h3ff);
        chk(busy === 1'b0 && done === 1'b0 && skip === 1'b0 && rd_data === '0,
            "R1 reset status", {15'd0, busy, done, skip, rd_data[13:0]}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_frame(3'd0, 10'h2a5, 16'h1234, 1'b1, 16'hdead, 1'b0);
        run_frame(3'd1, 10'h001, 16'h0000, 1'b1, 16'h0000, 1'b0);
        run_frame(3'd1, 10'h3ff, 16'h0000, 1'b0, 16'h0000, 1'b1);
        run_frame(3'd2, 10'h155, 16'hffff, 1'b1, 16'hbeef, 1'b0);
        run_frame(3'd2, 10'h0aa, 16'h0000, 1'b0, 16'h1111, 1'b1);
        run_frame(3'd2, 10'h000, 16'h0000, 1'b1, 16'h0000, 1'b1);
        run_frame(3'd3, 10'h1c3, 16'ha5a5, 1'b1, 16'h0000, 1'b0);
        run_frame(3'd3, 10'h1c3, 16'h5a5a, 1'b0, 16'h0000, 1'b1);
        run_frame(3'd4, 10'h3c0, 16'hffff, 1'b1, 16'h0000, 1'b0);
        run_frame(3'd4, 10'h3c0, 16'h0001, 1'b0, 16'h0000, 1'b1);
        for (int k = 5; k < 8; k++) run_frame(3'(k), 10'h111, 16'h8000, 1'b1, 16'h7777, 1'b1);
        for (int n = 0; n < 60; n++) begin
            run_frame(3'($urandom % 6), AW'($urandom), DW'($urandom), 1'($urandom),
                      DW'($urandom), 1'($urandom));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule